// File: doc/BRIEF.md
# Weight-Stationary bfloat16 Systolic Matrix Unit

This block multiplies a stream of left-hand row vectors by a resident right-hand matrix on an N x N grid of multiply-accumulate cells. Each weight is kept in its own cell. A load port writes the weight matrix one row per cycle. A single control bit, applied during the load, places the transpose of the matrix in the grid instead. Once the weights are resident, the client presents one left-hand row per accepted cycle. The unit returns the product row, which is that vector multiplied by the resident matrix.

The cells multiply two bfloat16 operands exactly. The product is widened to single precision and added to a partial sum that travels down the column. Activations move to the right and partial sums move down. The inputs are skewed by row on the way in, and the outputs are de-skewed by column on the way out, so that every finished row leaves the grid aligned. Finished rows go into a result FIFO that the consumer drains at its own pace. A credit counter stops new rows from entering once every FIFO slot is already spoken for, so the grid itself never has to stall.

Top module: `wsmx_array`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A weight-load beat with `wl_transpose`=0 and `wl_row`=r writes element c of `wl_data` (bits [16c+15:16c]) into the cell at grid row r, column c. Each result column j is then the sum over k of x[k]·W[k][j].
- R3: A weight-load beat with `wl_transpose`=1 and `wl_row`=r writes element c of `wl_data` into the cell at grid row c, column r. The resident matrix is therefore the transpose of the matrix that was loaded.
- R4: The bfloat16 product is exact and is formed with 1 sign bit, 8 exponent bits (bias 127) and 7 mantissa bits plus the hidden bit. Any operand whose exponent field is 0 is treated as zero and adds nothing to the sum. A result whose exponent would fall to 0 or below is flushed to +0.
- R5: Column j accumulates in single precision in order k = 0, 1, ..., N-1, starting from +0. At each addition:
  - the operand of smaller magnitude is shifted right and its shifted-out bits are discarded;
  - the significands are added or subtracted;
  - the result is normalised with truncation;
  - an exact cancellation gives +0.
- R6: When the FIFO is empty, a row accepted on one clock edge makes `out_valid` rise after 2N-1 further edges.
- R7: Result rows leave in the same order that their input rows were accepted.
- R8: `in_ready` is 1 exactly when the number of rows accepted but not yet popped is below FIFO_DEPTH. No accepted row is ever lost.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R10: Input element k occupies bits [16k+15:16k] of `in_data`. Output column j occupies bits [32j+31:32j] of `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wl_valid | input | 1 | Weight-load beat present |
| wl_row | input | max(1,clog2(N)) | Index of the matrix row being loaded |
| wl_transpose | input | 1 | Place the loaded row as a grid column |
| wl_data | input | N*16 | One bfloat16 matrix row |
| in_valid | input | 1 | Left-hand row present |
| in_ready | output | 1 | A left-hand row can be accepted |
| in_data | input | N*16 | Left-hand row, bfloat16 elements |
| out_valid | output | 1 | FIFO head holds a result row |
| out_ready | input | 1 | Consumer pops the head row |
| out_data | output | N*32 | Result row, single-precision elements |

## Verification
The bench builds the unit with N=4 and FIFO_DEPTH=4. At this size the full seven-edge skew and de-skew path can be seen from one latency measurement. Filling the FIFO takes only four rows, so the credit limit and the hold-while-stalled behaviour are reached many times under random consumer backpressure. Random operands are drawn from exponent ranges that are wide enough to make truncation and the accumulation order matter, yet narrow enough never to overflow. Zero and subnormal elements are mixed in to exercise the flush rule.

// File: rtl/wsmx_pkg.sv
package wsmx_pkg;

    typedef logic [15:0] bf16_t;
    typedef logic [31:0] fp32_t;

    typedef struct packed {
        bf16_t w;
        bf16_t x;
        fp32_t psum;
    } cell_st_t;

    // Exact bf16 x bf16 product widened to fp32; zero exponent flushes.
    function automatic fp32_t bf16_mul(input bf16_t a, input bf16_t b);
        logic [15:0] sig;
        logic [22:0] man;
        int          e;
        if (a[14:7] == 8'd0 || b[14:7] == 8'd0) return 32'd0;
        sig = {8'd0, 1'b1, a[6:0]} * {8'd0, 1'b1, b[6:0]};
        e   = int'(a[14:7]) + int'(b[14:7]) - 127;
        if (sig[15]) begin
            e   = e + 1;
            man = {sig[14:0], 8'd0};
        end else begin
            man = {sig[13:0], 9'd0};
        end
        if (e <= 0) return 32'd0;
        if (e >= 255) return {a[15] ^ b[15], 8'hFF, 23'd0};
        return {a[15] ^ b[15], e[7:0], man};
    endfunction

    // Truncating fp32 add; subnormal operands count as zero.
    function automatic fp32_t fp32_add(input fp32_t a, input fp32_t b);
        fp32_t       big, sml;
        logic [23:0] sb, ss, diff;
        logic [24:0] sum;
        int          e, d, top;
        if (a[30:23] == 8'd0) return (b[30:23] == 8'd0) ? 32'd0 : b;
        if (b[30:23] == 8'd0) return a;
        if (b[30:0] > a[30:0]) begin
            big = b; sml = a;
        end else begin
            big = a; sml = b;
        end
        e  = int'(big[30:23]);
        d  = e - int'(sml[30:23]);
        sb = {1'b1, big[22:0]};
        ss = (d >= 24) ? 24'd0 : ({1'b1, sml[22:0]} >> d);
        if (big[31] == sml[31]) begin
            sum = {1'b0, sb} + {1'b0, ss};
            if (sum[24]) begin
                sum = sum >> 1;
                e   = e + 1;
            end
            if (e >= 255) return {big[31], 8'hFF, 23'd0};
            return {big[31], e[7:0], sum[22:0]};
        end
        diff = sb - ss;
        if (diff == 24'd0) return 32'd0;
        top = 0;
        for (int i = 0; i < 24; i++) begin
            if (diff[i]) top = i;
        end
        diff = diff << (23 - top);
        e    = e - (23 - top);
        if (e <= 0) return 32'd0;
        return {big[31], e[7:0], diff[22:0]};
    endfunction

endpackage

// File: rtl/wsmx_delay.sv
module wsmx_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] sr_d [DEPTH];
    logic [W-1:0] sr_q [DEPTH];

    always_comb begin
        sr_d[0] = din;
        for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
        end
    end

    assign dout = sr_q[DEPTH-1];
endmodule

// File: rtl/wsmx_cell.sv
module wsmx_cell
    import wsmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  w_we,
    input  bf16_t w_in,
    input  bf16_t x_in,
    input  fp32_t psum_in,
    output bf16_t x_out,
    output fp32_t psum_out
);
    cell_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.x    = x_in;
        st_d.psum = fp32_add(psum_in, bf16_mul(x_in, st_q.w));
        if (w_we) st_d.w = w_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_out    = st_q.x;
    assign psum_out = st_q.psum;

    // R4
    zero_operand_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_in[14:7] == 8'd0) |=> (psum_out == $past(psum_in)));
endmodule

// File: rtl/wsmx_fifo.sv
module wsmx_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     pop;

    always_comb begin
        st_d = st_q;
        pop  = pop_req && (st_q.cnt != '0);
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH)) || pop);
    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop_req) |=> (head_valid && $stable(head_data)));
endmodule

// File: rtl/wsmx_array.sv
module wsmx_array
    import wsmx_pkg::*;
#(
    parameter int N          = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wl_valid,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] wl_row,
    input  logic                               wl_transpose,
    input  logic [N*16-1:0]                    wl_data,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [N*16-1:0]                    in_data,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [N*32-1:0]                    out_data
);
    localparam int RW  = (N > 1) ? $clog2(N) : 1;
    localparam int LAT = 2 * N - 1;
    localparam int CW  = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0]  used;
        logic [LAT-1:0] vtok;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    accept, pop;

    always_comb begin
        st_d      = st_q;
        accept    = in_valid && in_ready;
        pop       = out_valid && out_ready;
        st_d.used = st_q.used + CW'(accept) - CW'(pop);
        st_d.vtok = {st_q.vtok, accept} [LAT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = (st_q.used < CW'(FIFO_DEPTH));

    bf16_t x_edge  [N];
    bf16_t x_h     [N][N];
    fp32_t p_v     [N][N];
    bf16_t c_x_in  [N][N];
    fp32_t c_p_in  [N][N];
    logic  [N*32-1:0] row_out;

    for (genvar k = 0; k < N; k++) begin : g_skew
        bf16_t feed;
        assign feed = accept ? in_data[16*k +: 16] : 16'd0;
        if (k == 0) begin : g_direct
            assign x_edge[k] = feed;
        end else begin : g_dly
            wsmx_delay #(.W(16), .DEPTH(k)) u_dly (
                .clk(clk), .rst_n(rst_n), .din(feed), .dout(x_edge[k]));
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic  we;
            bf16_t wv;
            if (c == 0) begin : g_xl
                assign c_x_in[r][c] = x_edge[r];
            end else begin : g_xi
                assign c_x_in[r][c] = x_h[r][c-1];
            end
            if (r == 0) begin : g_pt
                assign c_p_in[r][c] = 32'd0;
            end else begin : g_pi
                assign c_p_in[r][c] = p_v[r-1][c];
            end
            assign we = wl_valid && (wl_transpose ? (wl_row == RW'(c))
                                                  : (wl_row == RW'(r)));
            assign wv = wl_transpose ? wl_data[16*r +: 16] : wl_data[16*c +: 16];
            wsmx_cell u_cell (
                .clk(clk), .rst_n(rst_n), .w_we(we), .w_in(wv),
                .x_in(c_x_in[r][c]), .psum_in(c_p_in[r][c]),
                .x_out(x_h[r][c]), .psum_out(p_v[r][c]));
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_deskew
        if (j == N - 1) begin : g_last
            assign row_out[32*j +: 32] = p_v[N-1][j];
        end else begin : g_dly
            wsmx_delay #(.W(32), .DEPTH(N - 1 - j)) u_dly (
                .clk(clk), .rst_n(rst_n), .din(p_v[N-1][j]),
                .dout(row_out[32*j +: 32]));
        end
    end

    wsmx_fifo #(.W(N * 32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(st_q.vtok[LAT-1]), .push_data(row_out),
        .pop_req(out_ready), .head_valid(out_valid), .head_data(out_data));

    // R8
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= CW'(FIFO_DEPTH));
    // R8
    inflight_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vtok) <= int'(st_q.used));
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/wsmx_array_test.sv
module wsmx_array_test;
    localparam int N = 4;
    localparam int D = 4;
    localparam int RW = 2;
    localparam int LIMIT = 150000;

    logic clk = 0, rst_n = 0;
    logic wl_valid = 0, wl_transpose = 0;
    logic [RW-1:0] wl_row = '0;
    logic [N*16-1:0] wl_data = '0, in_data = '0;
    logic in_valid = 0, out_ready = 0;
    logic in_ready, out_valid;
    logic [N*32-1:0] out_data;

    always #2 clk = ~clk;

    wsmx_array #(.N(N), .FIFO_DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .wl_valid(wl_valid), .wl_row(wl_row),
        .wl_transpose(wl_transpose), .wl_data(wl_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data));

    int nchk = 0, nfail = 0, cyc = 0, outstanding = 0;
    int send_pct = 100, rdy_pct = 100;
    bit timeout = 0, hold_prev = 0;
    logic [N*32-1:0] prev_data;
    logic [15:0] wcell [N][N];
    logic [15:0] bm [N][N];
    logic [N*32-1:0] exp_q [$];
    string tag_q [$];
    logic [N*16-1:0] pend_q [$];
    string ptag_q [$];

    function automatic logic [31:0] m_mul(logic [15:0] a, logic [15:0] b);
        int ma, mb, p, ex;
        logic [31:0] r;
        if (a[14:7] == 0 || b[14:7] == 0) return 32'd0;
        ma = 128 + int'(a[6:0]);
        mb = 128 + int'(b[6:0]);
        p  = ma * mb;
        ex = int'(a[14:7]) + int'(b[14:7]) - 127;
        if (p >= 32768) begin ex++; p = (p - 32768) << 8; end
        else            p = (p - 16384) << 9;
        if (ex <= 0) return 32'd0;
        r = {a[15] ^ b[15], 31'd0};
        if (ex >= 255) return r | 32'h7F80_0000;
        return r | (ex << 23) | p;
    endfunction

    function automatic logic [31:0] m_add(logic [31:0] a, logic [31:0] b);
        logic [31:0] hi, lo;
        int e, sh, sh_sig, sl, r;
        if (a[30:23] == 0) return (b[30:23] == 0) ? 32'd0 : b;
        if (b[30:23] == 0) return a;
        if (a[30:0] >= b[30:0]) begin hi = a; lo = b; end
        else begin hi = b; lo = a; end
        e = int'(hi[30:23]);
        sh = e - int'(lo[30:23]);
        sh_sig = (1 << 23) + int'(hi[22:0]);
        sl = (sh >= 24) ? 0 : (((1 << 23) + int'(lo[22:0])) >> sh);
        if (hi[31] == lo[31]) begin
            r = sh_sig + sl;
            if (r >= (1 << 24)) begin r = r >> 1; e++; end
            if (e >= 255) return {hi[31], 8'hFF, 23'd0};
        end else begin
            r = sh_sig - sl;
            if (r == 0) return 32'd0;
            while (r < (1 << 23)) begin r = r << 1; e--; end
            if (e <= 0) return 32'd0;
        end
        return {hi[31], e[7:0], r[22:0]};
    endfunction

    function automatic logic [N*32-1:0] m_row(logic [N*16-1:0] x);
        logic [N*32-1:0] res;
        for (int j = 0; j < N; j++) begin
            logic [31:0] acc = 32'd0;
            for (int k = 0; k < N; k++)
                acc = m_add(acc, m_mul(x[16*k +: 16], wcell[k][j]));
            res[32*j +: 32] = acc;
        end
        return res;
    endfunction

    function automatic logic [15:0] rnd_bf(int lo, int span);
        logic [7:0] e = 8'(lo + int'($urandom % span));
        return {1'($urandom), e, 7'($urandom)};
    endfunction

    task automatic check(bit ok, string tag, logic [N*32-1:0] act, logic [N*32-1:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) timeout = 1;
        if (hold_prev) // R9
            check(out_valid && out_data == prev_data, "R9", out_data, prev_data);
        // R8: credit rule seen at the port
        check(in_ready == (outstanding < D), "R8", N*32'(in_ready), N*32'(outstanding < D));
        if (out_valid && ($urandom % 100 < rdy_pct)) begin
            out_ready = 1;
            hold_prev = 0;
            if (exp_q.size() == 0) check(0, "R7", out_data, '0);
            else begin
                check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            outstanding--;
        end else begin
            out_ready = 0;
            hold_prev = out_valid;
            prev_data = out_data;
        end
        if (pend_q.size() > 0 && ($urandom % 100 < send_pct)) begin
            in_valid = 1;
            in_data  = pend_q[0];
            if (in_ready) begin
                exp_q.push_back(m_row(pend_q[0]));
                tag_q.push_back(ptag_q[0]);
                void'(pend_q.pop_front());
                void'(ptag_q.pop_front());
                outstanding++;
            end
        end else in_valid = 0;
    endtask

    task automatic drain();
        while ((pend_q.size() > 0 || outstanding > 0) && !timeout) tick();
        @(negedge clk);
        out_ready = 0; in_valid = 0; hold_prev = 0;
    endtask

    task automatic load_w(bit tr);
        for (int r = 0; r < N; r++) begin
            @(negedge clk);
            wl_valid = 1; wl_transpose = tr; wl_row = RW'(r);
            for (int c = 0; c < N; c++) begin
                wl_data[16*c +: 16] = bm[r][c];
                if (tr) wcell[c][r] = bm[r][c];
                else    wcell[r][c] = bm[r][c];
            end
        end
        @(negedge clk);
        wl_valid = 0;
    endtask

    task automatic queue_rows(int n, int lo, int span, int zero_pct, string tag);
        for (int i = 0; i < n; i++) begin
            logic [N*16-1:0] x;
            for (int k = 0; k < N; k++) begin
                x[16*k +: 16] = rnd_bf(lo, span);
                if ($urandom % 100 < zero_pct) x[16*k+7 +: 8] = 8'd0;
            end
            pend_q.push_back(x);
            ptag_q.push_back(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(!out_valid && in_ready, "R1", N*32'({out_valid, in_ready}), N*32'(2'b01));

        // R10: identity weights give each element back in its own column
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) bm[r][c] = (r == c) ? 16'h3F80 : 16'h0000;
        load_w(0);
        queue_rows(6, 118, 20, 0, "R10");
        send_pct = 100; rdy_pct = 100;
        drain();

        // R2: random resident matrix, random traffic
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) bm[r][c] = rnd_bf(120, 14);
        load_w(0);
        queue_rows(40, 120, 14, 0, "R2");
        send_pct = 70; rdy_pct = 70;
        drain();

        // R6: latency on an empty FIFO
        @(negedge clk);
        begin
            int k = 0;
            logic [N*16-1:0] x;
            for (int e = 0; e < N; e++) x[16*e +: 16] = rnd_bf(124, 6);
            in_valid = 1; in_data = x;
            exp_q.push_back(m_row(x)); tag_q.push_back("R6");
            outstanding++;
            do begin
                @(negedge clk);
                k++;
                if (k == 1) in_valid = 0;
            end while (!out_valid && k < 50);
            check(k == 2 * N, "R6", N*32'(k), N*32'(2 * N));
        end
        rdy_pct = 100;
        drain();

        // R3: transposed load of a non-symmetric matrix
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) bm[r][c] = rnd_bf(116, 22);
        load_w(1);
        queue_rows(40, 116, 22, 0, "R3");
        send_pct = 80; rdy_pct = 60;
        drain();

        // R4: zero and subnormal operands in data and weights
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                bm[r][c] = rnd_bf(120, 14);
                if ((r + c) % 3 == 0) bm[r][c][14:7] = 8'd0;
            end
        load_w(0);
        queue_rows(30, 120, 14, 35, "R4");
        send_pct = 90; rdy_pct = 80;
        drain();

        // R5: wide exponent spread and cancellation stress ordering and truncation
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) bm[r][c] = (c == 0) ? 16'h3F80 : rnd_bf(100, 50);
        load_w(0);
        begin
            logic [N*16-1:0] x;
            x[15:0] = 16'h4040; x[31:16] = 16'hC040; x[47:32] = 16'h3F81; x[63:48] = 16'hBF80;
            pend_q.push_back(x); ptag_q.push_back("R5");
        end
        queue_rows(40, 100, 50, 0, "R5");
        send_pct = 100; rdy_pct = 90;
        drain();

        // R8 and R7: stalled consumer fills every credit, then releases in order
        queue_rows(10, 120, 14, 0, "R7");
        send_pct = 100; rdy_pct = 0;
        repeat (30) tick();
        check(outstanding == D && !in_ready, "R8", N*32'(outstanding), N*32'(D));
        rdy_pct = 60;
        drain();

        if (timeout) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule